// File: doc/BRIEF.md
# Serial Control Register Write Port

This block accepts writes over a three-wire synchronous serial link made of a data line, a clock line and an enable line, and holds the result in a bank of eight 5-bit control registers. The port is a slave and is write-only: nothing can be read back over the link. A controller raises enable and clocks bits in on rising serial clock edges, least significant bit first. When enable drops, the port decodes the eight most recent bits. The top three bits pick one register and the lower five bits are the value written into it.

The three serial lines are treated as asynchronous to the system clock. Each line passes through a two-flop synchronizer, and the edges of the serial clock and of enable are found by comparing successive synchronized samples. All eight registers are driven out in parallel on one flat bus, so the logic they control can use them directly. Between two frames the enable line must be low long enough for the system clock to see it low.

Top module: `serial_ctrl_bank`

## Requirements
- R1: After reset, all eight registers read zero on `regs_o`. Register k sits in `regs_o[5k+4:5k]`.
- R2: While enable is high, each rising serial clock edge shifts in one bit. The first bit sent becomes frame bit 0 and the eighth becomes frame bit 7. Frame bits [7:5] give the register index and bits [4:0] give the data.
- R3: On the falling edge of enable, a complete frame writes its data into the indexed register only. The other seven registers keep their values.
- R4: If more than eight bits are clocked in one enable window, only the last eight form the frame.
- R5: If fewer than eight bits are clocked in one enable window, the write is dropped and no register changes.
- R6: While enable is low, toggling the serial clock and data lines changes no register and does not disturb the next frame.
- R7: A committed value appears on `regs_o` at the third rising system clock edge after `ser_en` falls. It does not appear at the second.
- R8: Two frames separated by a short enable-low gap of four system clocks both commit, each to its own register.
- R9: A later write to the same register replaces the earlier value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ser_clk | input | 1 | Serial bit clock, asynchronous |
| ser_dat | input | 1 | Serial data, least significant bit first |
| ser_en | input | 1 | Frame enable, high while bits are sent |
| regs_o | output | 40 | All eight 5-bit registers; register k at bits [5k+4:5k] |

## Verification
A table of full 8-bit frames is sent with different indices and bit patterns, including all-ones, all-zeros and alternating data. These frames show whether the bit order and the index/data split are correct, and whether writes leak into neighbouring registers. Frames of five bits and of eleven bits tell a discarded partial frame apart from a frame taken from the last eight bits. Clock and data activity while enable is low, back-to-back frames with a minimal gap, and a cycle-exact look at the commit edge separate correct gating and synchronizer latency from an off-by-one pipeline.

// File: rtl/serial_ctrl_bank.sv
module serial_ctrl_bank #(
  parameter int ADDR_W = 3,
  parameter int DATA_W = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_dat,
  input  logic ser_en,
  output logic [(2**ADDR_W)*DATA_W-1:0] regs_o
);

  localparam int FRAME_W = ADDR_W + DATA_W;
  localparam int NREG    = 2**ADDR_W;
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);

  logic [SYNC_STAGES-1:0] clk_sync, dat_sync, en_sync;
  logic clk_s, dat_s, en_s;
  logic clk_p, en_p;
  logic sclk_rise, en_rise, en_fall;
  logic [FRAME_W-1:0] shreg;
  logic [CNT_W-1:0] bit_cnt;
  logic frame_ok;
  logic [ADDR_W-1:0] wr_addr;
  logic [DATA_W-1:0] wr_data;
  logic [DATA_W-1:0] regs_q [NREG];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sync <= '0;
      dat_sync <= '0;
      en_sync  <= '0;
      clk_p    <= 1'b0;
      en_p     <= 1'b0;
    end else begin
      clk_sync <= {clk_sync[SYNC_STAGES-2:0], ser_clk};
      dat_sync <= {dat_sync[SYNC_STAGES-2:0], ser_dat};
      en_sync  <= {en_sync[SYNC_STAGES-2:0],  ser_en};
      clk_p    <= clk_s;
      en_p     <= en_s;
    end
  end

  assign clk_s = clk_sync[SYNC_STAGES-1];
  assign dat_s = dat_sync[SYNC_STAGES-1];
  assign en_s  = en_sync[SYNC_STAGES-1];

  assign sclk_rise = en_s && clk_s && !clk_p;
  assign en_rise   = en_s && !en_p;
  assign en_fall   = !en_s && en_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      bit_cnt <= '0;
    end else if (en_rise) begin
      bit_cnt <= '0;
    end else if (sclk_rise) begin
      shreg <= {dat_s, shreg[FRAME_W-1:1]};
      if (bit_cnt != CNT_FULL) bit_cnt <= bit_cnt + 1'b1;
    end
  end

  assign frame_ok = (bit_cnt == CNT_FULL);
  assign wr_addr  = shreg[FRAME_W-1:DATA_W];
  assign wr_data  = shreg[DATA_W-1:0];

  for (genvar k = 0; k < NREG; k++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        regs_q[k] <= '0;
      else if (en_fall && frame_ok && wr_addr == ADDR_W'(k))
        regs_q[k] <= wr_data;
    end
    assign regs_o[k*DATA_W +: DATA_W] = regs_q[k];

    // R3
    other_reg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (en_fall && wr_addr != ADDR_W'(k)) |=> $stable(regs_o[k*DATA_W +: DATA_W]));
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= CNT_FULL);

  // R6
  idle_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_s |=> $stable(shreg));

  // R5
  short_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_fall && !frame_ok) |=> $stable(regs_o));

  // R7
  commit_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !en_fall |=> $stable(regs_o));

endmodule

// File: tb/serial_ctrl_bank_tb.sv
module serial_ctrl_bank_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ser_clk = 1'b0, ser_dat = 1'b0, ser_en = 1'b0;
  logic [39:0] regs_o;
  logic [4:0] model [8];
  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  serial_ctrl_bank dut_i (.clk(clk), .rst_n(rst_n), .ser_clk(ser_clk),
    .ser_dat(ser_dat), .ser_en(ser_en), .regs_o(regs_o));

  // {frame[7:0], expected index[2:0], expected data[4:0]}
  localparam logic [15:0] VEC [8] = '{
    {8'h3F, 3'd1, 5'h1F}, {8'hE0, 3'd7, 5'h00}, {8'h4A, 3'd2, 5'h0A},
    {8'hD5, 3'd6, 5'h15}, {8'h11, 3'd0, 5'h11}, {8'h6E, 3'd3, 5'h0E},
    {8'h9B, 3'd4, 5'h1B}, {8'hA4, 3'd5, 5'h04}};

  task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [39:0] model_bus();
    logic [39:0] b;
    for (int k = 0; k < 8; k++) b[k*5 +: 5] = model[k];
    return b;
  endfunction

  task automatic clocks(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic shift_bits(input logic [15:0] bits, input int n);
    ser_en = 1'b1;
    clocks(4);
    for (int i = 0; i < n; i++) begin
      ser_dat = bits[i];
      clocks(4);
      ser_clk = 1'b1;
      clocks(4);
      ser_clk = 1'b0;
    end
    clocks(4);
  endtask

  task automatic send(input logic [15:0] bits, input int n, input int gap);
    shift_bits(bits, n);
    ser_en = 1'b0;
    clocks(gap);
  endtask

  task automatic apply(input logic [7:0] f);
    model[f[7:5]] = f[4:0];
  endtask

  task automatic finish_up();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_up();
    end
  end

  initial begin
    for (int k = 0; k < 8; k++) model[k] = '0;
    clocks(3);
    rst_n = 1'b1;
    clocks(2);
    check("R1 reset", regs_o, 40'h0);

    // R2 R3: table of full frames
    for (int v = 0; v < 8; v++) begin
      send({8'h00, VEC[v][15:8]}, 8, 8);
      model[VEC[v][7:5]] = VEC[v][4:0];
      check("R2 field", {35'h0, regs_o[VEC[v][7:5]*5 +: 5]}, {35'h0, VEC[v][4:0]});
      check("R3 others", regs_o, model_bus());
    end

    // R5: five bits only
    send(16'h001F, 5, 8);
    check("R5 short", regs_o, model_bus());

    // R4: eleven bits, last eight used (bits[10:3])
    send(16'h0635, 11, 8);
    apply(8'(16'h0635 >> 3));
    check("R4 long", regs_o, model_bus());

    // R6: activity with enable low
    for (int i = 0; i < 6; i++) begin
      ser_dat = i[0]; clocks(4); ser_clk = 1'b1; clocks(4); ser_clk = 1'b0;
    end
    clocks(6);
    check("R6 idle", regs_o, model_bus());
    send(16'h0027, 8, 8);
    apply(8'h27);
    check("R6 next frame", regs_o, model_bus());

    // R7: cycle-exact commit
    shift_bits(16'h00B9, 8);
    ser_en = 1'b0;
    clocks(2);
    check("R7 not yet", regs_o, model_bus());
    apply(8'hB9);
    clocks(1);
    check("R7 commit", regs_o, model_bus());
    clocks(5);

    // R8: back to back with 4-cycle gap
    send(16'h0068, 8, 4);
    send(16'h00F3, 8, 8);
    apply(8'h68); apply(8'hF3);
    check("R8 back-to-back", regs_o, model_bus());

    // R9: overwrite same register
    send(16'h0041, 8, 8);
    send(16'h005E, 8, 8);
    apply(8'h41); apply(8'h5E);
    check("R9 overwrite", regs_o, model_bus());

    done = 1'b1;
    finish_up();
  end
endmodule